// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel. It takes one tick per edge of its count clock. A load strobe carries a 16-bit initial count N and a 3-bit mode code. A value of zero stands for 65536. The channel then shapes its output line according to the mode and presents its current count so that a separate host interface can latch and read it.

There are six behaviours:
- Terminal flag (0): the output rises and stays high.
- Gate-triggered one-shot (1).
- Rate generator (2): a one-tick pulse every N ticks.
- Square wave (3): the count moves down by two per tick.
- Software strobe (4).
- Gate-triggered strobe (5).

Codes 6 and 7 alias modes 2 and 3.

The gate input has two roles. In some modes a rising edge restarts the sequence. In others the gate level pauses counting.

The control is a state machine with four states:
- ST_RUN counts toward the terminal tick.
- ST_STROBE is the one-tick output pulse of modes 2, 4 and 5.
- ST_DONE is past the terminal tick, and the count keeps wrapping.
- ST_CYCLE is the free-running phase of modes 2 and 3.

The transitions are as follows:
- A load or a restart sends the channel to ST_CYCLE in a periodic mode, or to ST_RUN otherwise.
- ST_RUN goes to ST_STROBE (modes 4/5) or to ST_DONE (modes 0/1) on the tick that brings the count to zero.
- ST_STROBE goes to ST_DONE on the next tick in a one-shot mode.
- In mode 2, ST_CYCLE goes to ST_STROBE on the tick that wraps the phase, and ST_STROBE goes back to ST_CYCLE on the tick after.

Top module: `interval_channel`

## Requirements
- R1: A load with value 0 is treated as N = 65536. The count reads 0x0000 on the cycle after the load and 65536 - d afterwards (d = ticks counted since the load).
- R2: In modes 0, 1, 4 and 5 the count reads (N - d) mod 65536, and it keeps wrapping after the terminal tick.
- R3: In mode 0 the output is low until d reaches N. It then stays high until the next load.
- R4: In mode 2 the output is high exactly when d is a nonzero multiple of N, and the count reads N - (d mod N), modulo 65536.
- R5: In mode 3 the output is high when (d mod N) < (N+1)/2 and low otherwise. The count reads N - ((2d) mod N), modulo 65536.
- R6: In modes 4 and 5 the output is high only while d equals N.
- R7: A rising gate edge (gate high now, low at the previous clock edge) resets d to 0 in modes 1, 2, 3 and 5. In mode 1 the output is high when d >= N. Modes 1 and 5 count regardless of the gate level.
- R8: In modes 0, 2, 3 and 4 no tick is counted on an edge where the gate is low, so the count holds. In modes 2 and 3 the output is high whenever the gate is low.
- R9: Mode code 6 behaves exactly as mode 2, and code 7 exactly as mode 3.
- R10: After reset the channel is in mode 3 with N = 65536, d = 0 (count 0x0000, output high). The previous-gate level is taken as the GATE_RST parameter (default 1), so a gate held high through reset gives no restart.
- R11: A load sampled at a clock edge sets d = 0 with the new N and mode at that edge. It takes priority over a simultaneous gate restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; one tick per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_stb | input | 1 | Load the initial count and mode at this edge |
| load_value | input | 16 | Initial count; 0 means 65536 |
| load_mode | input | 3 | Mode code 0..7 |
| gate_in | input | 1 | Gate level |
| out_wave | output | 1 | Channel output line |
| count_value | output | 16 | Current readable count |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- A zero load: a design that loads a literal zero would hit the terminal tick at once.
- N = 1 in the periodic modes: an off-by-one in the phase wrap would give a pulse every two ticks, or none.
- Odd N in square-wave mode: a wrong half-period would shift the falling edge by one tick.
- Gate-low pauses in modes 0 and 4: a channel that kept counting would reach the terminal tick early.
- Gate-low forcing in modes 2 and 3: a missing force would leave the output low while paused.
- Gate rises in modes 1 and 5: a missing retrigger would leave the terminal tick at its old position.
- Aliased codes 6 and 7: a missing alias would fall into strobe behaviour.
- A load colliding with a gate rise: a wrong priority would keep the old N.

// File: rtl/interval_channel_pkg.sv
package interval_channel_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } mode_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_STROBE,
        ST_DONE,
        ST_CYCLE
    } state_t;

    function automatic mode_t norm_mode(input logic [2:0] code);
        unique case (code)
            3'd6:    return MD_RATE;
            3'd7:    return MD_SQUARE;
            default: return mode_t'(code);
        endcase
    endfunction

    function automatic logic is_periodic(input mode_t m);
        return (m == MD_RATE) || (m == MD_SQUARE);
    endfunction

    function automatic logic is_strobe(input mode_t m);
        return (m == MD_SWSTB) || (m == MD_HWSTB);
    endfunction

    function automatic logic is_gated(input mode_t m);
        return (m == MD_TERM) || (m == MD_SWSTB) || is_periodic(m);
    endfunction

    function automatic logic is_edge_mode(input mode_t m);
        return (m == MD_ONESHOT) || (m == MD_HWSTB) || is_periodic(m);
    endfunction

endpackage

// File: rtl/interval_gate_ctl.sv
module interval_gate_ctl
    import interval_channel_pkg::*;
#(
    parameter logic GATE_RST = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  gate_in,
    input  mode_t mode_q,
    output logic  tick_en,
    output logic  restart
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= GATE_RST;
        else        gate_q <= gate_in;
    end

    assign tick_en = is_gated(mode_q) ? gate_in : 1'b1;
    assign restart = gate_in && !gate_q && is_edge_mode(mode_q);
endmodule

// File: rtl/interval_seq_core.sv
module interval_seq_core
    import interval_channel_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] load_value,
    input  logic [2:0]   load_mode,
    input  logic         tick_en,
    input  logic         restart,
    input  logic         gate_in,
    output mode_t        mode_q,
    output logic [W:0]   init_q,
    output logic [W:0]   phase_q,
    output logic [W-1:0] cnt_q,
    output logic         out_wave
);
    localparam logic [W:0]   FULL = {1'b1, {W{1'b0}}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    state_t       st_q, st_d;
    mode_t        mode_d;
    logic [W:0]   init_d, phase_d, ph_inc, half;
    logic [W-1:0] cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_CYCLE;
            mode_q  <= MD_SQUARE;
            init_q  <= FULL;
            phase_q <= '0;
            cnt_q   <= '0;
        end else begin
            st_q    <= st_d;
            mode_q  <= mode_d;
            init_q  <= init_d;
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        mode_d  = mode_q;
        init_d  = init_q;
        phase_d = phase_q;
        cnt_d   = cnt_q;
        ph_inc  = phase_q + 1'b1;
        if (load_stb) begin
            init_d  = (load_value == '0) ? FULL : {1'b0, load_value};
            mode_d  = norm_mode(load_mode);
            phase_d = '0;
            cnt_d   = load_value;
            st_d    = is_periodic(mode_d) ? ST_CYCLE : ST_RUN;
        end else if (restart) begin
            phase_d = '0;
            cnt_d   = init_q[W-1:0];
            st_d    = is_periodic(mode_q) ? ST_CYCLE : ST_RUN;
        end else if (tick_en) begin
            unique case (st_q)
                ST_RUN: begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == ONE)
                        st_d = is_strobe(mode_q) ? ST_STROBE : ST_DONE;
                end
                ST_STROBE, ST_CYCLE: begin
                    if (is_periodic(mode_q)) begin
                        if (ph_inc == init_q) begin
                            phase_d = '0;
                            st_d    = (mode_q == MD_RATE) ? ST_STROBE : ST_CYCLE;
                        end else begin
                            phase_d = ph_inc;
                            st_d    = ST_CYCLE;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                        st_d  = ST_DONE;
                    end
                end
                ST_DONE: cnt_d = cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign half = {1'b0, init_q[W:1]} + {{W{1'b0}}, init_q[0]};

    always_comb begin
        unique case (st_q)
            ST_RUN:    out_wave = 1'b0;
            ST_STROBE: out_wave = 1'b1;
            ST_DONE:   out_wave = (mode_q == MD_TERM) || (mode_q == MD_ONESHOT);
            ST_CYCLE:  out_wave = (mode_q == MD_SQUARE) && (phase_q < half);
            default:   out_wave = 1'b0;
        endcase
        if (is_periodic(mode_q) && !gate_in) out_wave = 1'b1;
    end
endmodule

// File: rtl/interval_count_view.sv
module interval_count_view
    import interval_channel_pkg::*;
#(
    parameter int W = 16
) (
    input  mode_t        mode_q,
    input  logic [W:0]   init_q,
    input  logic [W:0]   phase_q,
    input  logic [W-1:0] cnt_q,
    output logic [W-1:0] count_value
);
    logic [W+1:0] dbl, red, init_x;

    assign init_x = {1'b0, init_q};
    assign dbl    = {phase_q, 1'b0};
    assign red    = (dbl >= init_x) ? (dbl - init_x) : dbl;

    always_comb begin
        unique case (mode_q)
            MD_RATE:   count_value = W'(init_q - phase_q);
            MD_SQUARE: count_value = W'(init_x - red);
            default:   count_value = cnt_q;
        endcase
    end
endmodule

// File: rtl/interval_channel.sv
module interval_channel
    import interval_channel_pkg::*;
#(
    parameter int   W        = 16,
    parameter logic GATE_RST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] load_value,
    input  logic [2:0]   load_mode,
    input  logic         gate_in,
    output logic         out_wave,
    output logic [W-1:0] count_value
);
    mode_t        mode_q;
    logic [W:0]   init_q, phase_q;
    logic [W-1:0] cnt_q;
    logic         tick_en, restart;

    interval_gate_ctl #(.GATE_RST(GATE_RST)) i_gate (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .mode_q(mode_q),
        .tick_en(tick_en), .restart(restart)
    );

    interval_seq_core #(.W(W)) i_core (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_value(load_value),
        .load_mode(load_mode), .tick_en(tick_en), .restart(restart),
        .gate_in(gate_in), .mode_q(mode_q), .init_q(init_q), .phase_q(phase_q),
        .cnt_q(cnt_q), .out_wave(out_wave)
    );

    interval_count_view #(.W(W)) i_view (
        .mode_q(mode_q), .init_q(init_q), .phase_q(phase_q), .cnt_q(cnt_q),
        .count_value(count_value)
    );
endmodule

// File: rtl/interval_channel_chk.sv
module interval_channel_chk
    import interval_channel_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_stb,
    input logic [W-1:0] load_value,
    input logic         gate_in,
    input logic         out_wave,
    input logic [W-1:0] count_value,
    input mode_t        mode_q,
    input logic         tick_en,
    input logic         restart
);
    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> count_value == $past(load_value)); // R11

    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TERM && out_wave && !load_stb) |=> out_wave); // R3

    AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_strobe(mode_q) && out_wave && tick_en && !load_stb && !restart) |=> !out_wave); // R6

    AST_ONESHOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_periodic(mode_q) && tick_en && !load_stb && !restart)
            |=> count_value == W'($past(count_value) - 1'b1)); // R2

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_TERM || mode_q == MD_SWSTB) && !gate_in && !load_stb)
            |=> $stable(count_value)); // R8

    AST_GATE_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_periodic(mode_q) && !gate_in) |-> out_wave); // R8
endmodule

bind interval_channel interval_channel_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_value(load_value),
    .gate_in(gate_in), .out_wave(out_wave), .count_value(count_value),
    .mode_q(mode_q), .tick_en(tick_en), .restart(restart)
);

// File: tb/test_interval_channel.sv
module test_interval_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [15:0] load_value = '0;
    logic [2:0]  load_mode = '0;
    logic        gate_in = 1'b1;
    logic        out_wave;
    logic [15:0] count_value;

    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 0;
    string  tag = "";
    int     m_mode;
    longint m_n, m_d;
    bit     m_prev;

    interval_channel i_interval_channel (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_value(load_value),
        .load_mode(load_mode), .gate_in(gate_in), .out_wave(out_wave),
        .count_value(count_value)
    );

    always #5 clk = ~clk;

    function automatic int norm(int m);
        return (m == 6) ? 2 : (m == 7) ? 3 : m;
    endfunction

    function automatic bit exp_out(int m, longint n, longint d, bit g);
        case (m)
            0, 1:    return d >= n;
            2:       return !g || ((d % n) == 0 && d != 0);
            3:       return !g || ((d % n) < (n + 1) / 2);
            default: return d == n;
        endcase
    endfunction

    function automatic int exp_cnt(int m, longint n, longint d);
        case (m)
            2:       return int'((n - (d % n)) & 65535);
            3:       return int'((n - ((2 * d) % n)) & 65535);
            default: return int'((n - d) & 65535);
        endcase
    endfunction

    function automatic string mode_req(int m);
        case (m)
            0: return "R3";
            1: return "R7";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
        end
    endtask

    task automatic check_now();
        bit eo;
        int ec;
        string ro, rc;
        eo = exp_out(m_mode, m_n, m_d, gate_in);
        ec = exp_cnt(m_mode, m_n, m_d);
        ro = (tag != "") ? tag : mode_req(m_mode);
        rc = (tag != "") ? tag : ((m_mode == 2 || m_mode == 3) ? mode_req(m_mode) : "R2");
        chk(out_wave == eo, ro, "out_wave", int'(out_wave), int'(eo));
        chk(int'(count_value) == ec, rc, "count_value", int'(count_value), ec);
    endtask

    task automatic tick(bit ld, int val, int md, bit g);
        int nm;
        load_stb = ld; load_value = val[15:0]; load_mode = md[2:0]; gate_in = g;
        #6;
        check_now();
        @(posedge clk);
        if (ld) begin
            m_n = (val[15:0] == 0) ? 65536 : longint'(val[15:0]);
            m_mode = norm(md);
            m_d = 0;
        end else begin
            nm = m_mode;
            if (g && !m_prev && (nm == 1 || nm == 2 || nm == 3 || nm == 5)) m_d = 0;
            else if (!(nm == 0 || nm == 2 || nm == 3 || nm == 4) || g) m_d++;
        end
        m_prev = g;
        #2;
    endtask

    task automatic run(int cycles, bit g);
        for (int i = 0; i < cycles; i++) tick(0, 0, 0, g);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mode = 3; m_n = 65536; m_d = 0; m_prev = 1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R10: reset defaults
        chk(count_value == 16'h0000, "R10", "reset count", int'(count_value), 0);
        chk(out_wave == 1'b1, "R10", "reset out", int'(out_wave), 1);
        tag = "R10"; run(6, 1);
        // R1: zero load is 65536
        tag = "R1"; tick(1, 0, 0, 1); run(6, 1);
        // R3: mode 0 terminal flag
        tag = "R3"; tick(1, 5, 0, 1); run(10, 1);
        // R8: gate low holds mode 0, forces periodic high
        tag = "R8"; tick(1, 6, 0, 1); run(2, 1); run(4, 0); run(8, 1);
        tick(1, 4, 2, 1); run(3, 1); run(3, 0); run(9, 1);
        tick(1, 4, 4, 1); run(4, 1); run(3, 0); run(4, 1);
        // R4: rate generator, incl. N=1
        tag = "R4"; tick(1, 3, 2, 1); run(10, 1); tick(1, 1, 2, 1); run(4, 1);
        // R5: square wave, odd and N=1
        tag = "R5"; tick(1, 5, 3, 1); run(12, 1); tick(1, 1, 3, 1); run(3, 1);
        // R6: strobes
        tag = "R6"; tick(1, 3, 4, 1); run(6, 1); tick(1, 3, 5, 1); run(6, 1);
        // R9: aliases
        tag = "R9"; tick(1, 5, 6, 1); run(12, 1); tick(1, 7, 7, 1); run(16, 1);
        // R7: gate retrigger in one-shot modes
        tag = "R7"; tick(1, 4, 1, 1); run(2, 1); run(2, 0); run(7, 1);
        tick(1, 4, 5, 0); run(2, 0); run(8, 1);
        // R11: load mid-run and load colliding with gate rise
        tag = "R11"; tick(1, 9, 0, 1); run(3, 1); tick(1, 3, 2, 1); run(4, 1);
        tick(1, 8, 3, 0); run(2, 0); tick(1, 2, 1, 1); run(5, 1);
        // random mix
        tag = "";
        begin
            bit g = 1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(7) == 0) g = !g;
                if ($urandom_range(39) == 0)
                    tick(1, ($urandom_range(15) == 0) ? 0 : int'($urandom_range(1, 20)),
                         int'($urandom_range(7)), g);
                else
                    tick(0, 0, 0, g);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule